// File: doc/BRIEF.md
# Watchdog Timer with Selectable Count Source

This block guards against runaway software. It counts ticks from one of two sources and raises a one-cycle reset pulse if software fails to clear it in time. A static configuration input chooses the source. One choice is an enable pulse from a free-running slow oscillator, which keeps running while the core is halted. The other is an instruction-rate enable, made inside the block by dividing the system clock by four. The divided clock is also driven out so that external logic can synchronise to the instruction rate.

The count chain has two stages. A fixed 256-step base stage comes first. A prescaler follows, with a ratio of 2^WS, where WS is a 3-bit select field held in a writable register. The full time-out is therefore 256 × 2^WS source ticks, from 256 up to 32768. A second static configuration input switches the whole watchdog off. While it is off, clears and select writes do nothing, and no reset can be produced.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `wdt_rst` is low, `sel_q` reads 3'b111, both count stages are zero, and the divide-by-four counter is zero.
- R2: Suppose the last clear or time-out came at tick count 0. The time-out occurs on the 256 × 2^WS-th tick of the selected source, where WS is the value in `sel_q`. `wdt_rst` is then high for exactly the one cycle after the clock edge that took that final tick.
- R3: After a time-out, counting restarts from zero. Without a clear, the next pulse follows after another 256 × 2^WS ticks.
- R4: A high `clr_wdt` sets both stages to zero on that edge. It takes priority over a tick on the same edge, including the tick that would have ended the count, and no pulse follows it.
- R5: With `cfg_use_osc` = 1, only `osc_tick` advances the count. With `cfg_use_osc` = 0, only the internal instruction-rate enable `icyc_en` advances it.
- R6: A 2-bit counter advances on each cycle in which `halt` is low, and holds while `halt` is high. `icyc_en` is high when the counter equals 3 and `halt` is low, which is one cycle in four. `sync_out` is bit 1 of the counter, so it is low for two cycles and high for two.
- R7: With `cfg_use_osc` = 1, a high `halt` does not stop the watchdog. Time-outs keep occurring on schedule.
- R8: When `sel_we` is high, `sel_q` takes `sel_wdata` on the next edge and the count is not cleared. The pulse then comes at the first base-stage wrap at which the prescaler count is at least 2^WS − 1 for the new WS.
- R9: While `cfg_enable` is low, both stages are held at zero and `wdt_rst` stays low. `clr_wdt` and `sel_we` have no effect, and `sel_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Static option: watchdog present when high |
| cfg_use_osc | input | 1 | Static option: 1 counts the slow oscillator, 0 counts instruction cycles |
| osc_tick | input | 1 | One-cycle enable from the slow oscillator |
| halt | input | 1 | Power-down: stops the instruction-rate divider |
| clr_wdt | input | 1 | Software clear strobe |
| sel_we | input | 1 | Write strobe for the prescaler select register |
| sel_wdata | input | 3 | New prescaler select value |
| sel_q | output | 3 | Current prescaler select value |
| icyc_en | output | 1 | Instruction-rate clock enable |
| sync_out | output | 1 | System clock divided by four, for external logic |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench schedules each expected pulse to the exact cycle, for the shortest and the longest prescaler ratio and across the automatic restart. An off-by-one in the terminal count, or a chain that fails to restart, would land a pulse on the wrong cycle or produce none. A clear is issued on the very edge that would end the count; a design that lets the tick win there would emit a stray pulse. The select value is shrunk below the prescaler count already reached, so an equality compare would let the prescaler run on and miss the expected pulse. Halted runs in both source modes separate a watchdog that wrongly stops on the slow oscillator from one that wrongly keeps counting instruction cycles.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int BASE_BITS = 8,
  parameter int SEL_W     = 3,
  parameter int DIV_BITS  = 2,
  parameter int SEL_INIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_use_osc,
  input  logic             osc_tick,
  input  logic             halt,
  input  logic             clr_wdt,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             icyc_en,
  output logic             sync_out,
  output logic             wdt_rst
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [DIV_BITS-1:0]  div_q;
  logic [BASE_BITS-1:0] base_q;
  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     pre_term;
  logic                 tick, base_wrap, fire;

  assign icyc_en   = (&div_q) & ~halt;
  assign sync_out  = div_q[DIV_BITS-1];
  assign tick      = cfg_use_osc ? osc_tick : icyc_en;
  assign pre_term  = ~({PRE_W{1'b1}} << sel_q);
  assign base_wrap = tick & (&base_q);
  assign fire      = base_wrap & (pre_q >= pre_term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (!halt)
      div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= SEL_W'(SEL_INIT);
    else if (cfg_enable && sel_we)
      sel_q <= sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      pre_q   <= '0;
      wdt_rst <= 1'b0;
    end else if (!cfg_enable || clr_wdt) begin
      base_q  <= '0;
      pre_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      wdt_rst <= fire;
      if (tick)
        base_q <= base_q + 1'b1;
      if (fire)
        pre_q <= '0;
      else if (base_wrap)
        pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic             halt,
  input logic             clr_wdt,
  input logic             sel_we,
  input logic [SEL_W-1:0] sel_wdata,
  input logic [SEL_W-1:0] sel_q,
  input logic             icyc_en,
  input logic             sync_out,
  input logic             wdt_rst
);
  AST_PULSE_ONE:   assert property (@(posedge clk) disable iff (!rst_n) wdt_rst |=> !wdt_rst);                            // R2
  AST_CLR_WINS:    assert property (@(posedge clk) disable iff (!rst_n) clr_wdt |=> !wdt_rst);                            // R4
  AST_ICYC_GAP:    assert property (@(posedge clk) disable iff (!rst_n) icyc_en |=> !icyc_en);                            // R6
  AST_ICYC_PHASE:  assert property (@(posedge clk) disable iff (!rst_n) icyc_en |-> sync_out);                            // R6
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) halt |=> $stable(sync_out));                      // R6
  AST_SEL_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) (cfg_enable && sel_we) |=> sel_q == $past(sel_wdata)); // R8
  AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !cfg_enable |=> !wdt_rst);                        // R9
  AST_OFF_SEL:     assert property (@(posedge clk) disable iff (!rst_n) !cfg_enable |=> $stable(sel_q));                  // R9
endmodule

bind wdog_timer wdog_timer_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .halt(halt), .clr_wdt(clr_wdt),
  .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q), .icyc_en(icyc_en),
  .sync_out(sync_out), .wdt_rst(wdt_rst)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b1, cfg_use_osc = 1'b1, osc_tick = 1'b0, halt = 1'b0;
  logic clr_wdt = 1'b0, sel_we = 1'b0;
  logic [2:0] sel_wdata = 3'd0;
  logic [2:0] sel_q;
  logic icyc_en, sync_out, wdt_rst;

  int pcyc = 0;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int pulse_cnt = 0;
  bit want_catch = 0;
  int caught = -1;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_use_osc(cfg_use_osc),
    .osc_tick(osc_tick), .halt(halt), .clr_wdt(clr_wdt), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .sel_q(sel_q), .icyc_en(icyc_en), .sync_out(sync_out),
    .wdt_rst(wdt_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, pcyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wdt_rst) begin
      pulse_cnt++;
      if (want_catch && caught < 0) caught = pcyc;
      else if (exp_q.size() == 0) chk(0, "R2/R9 unexpected pulse", pcyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(pcyc == e, "R2/R3 pulse cycle", pcyc, e);
      end
    end
  end

  task automatic wait_until(input int t);
    while (pcyc < t) @(negedge clk);
  endtask

  task automatic arm(input logic [2:0] ws, output int p);
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    cfg_enable = 1'b1; clr_wdt = 1'b1; sel_we = 1'b1; sel_wdata = ws;
    p = pcyc;
    @(negedge clk);
    clr_wdt = 1'b0; sel_we = 1'b0;
  endtask

  task automatic stop(input string req);
    cfg_enable = 1'b0;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    int p, n_ic, n_sy, pc0;
    logic s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wdt_rst == 1'b0, "R1 wdt_rst", wdt_rst, 0);
    chk(sel_q == 3'd7, "R1 sel_q", sel_q, 7);

    n_ic = 0; n_sy = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n_ic += icyc_en; n_sy += sync_out;
    end
    chk(n_ic == 100, "R6 icyc_en rate", n_ic, 100);
    chk(n_sy == 200, "R6 sync_out duty", n_sy, 200);

    // R2 R3: oscillator source, ratio 1:1, two pulses across the restart
    cfg_use_osc = 1'b1; osc_tick = 1'b1;
    arm(3'd0, p);
    exp_q.push_back(p + 1 + 256);
    exp_q.push_back(p + 1 + 512);
    wait_until(p + 520);
    stop("R3 restart pulses seen");

    // R4: clear on the edge of the final tick
    arm(3'd0, p);
    exp_q.push_back(p + 257 + 256);
    wait_until(p + 256); clr_wdt = 1'b1;
    wait_until(p + 257); clr_wdt = 1'b0;
    wait_until(p + 520);
    stop("R4 clear wins");

    // R5: oscillator selected but idle, so instruction ticks must not count
    osc_tick = 1'b0;
    pc0 = pulse_cnt;
    arm(3'd0, p);
    wait_until(p + 1300);
    chk(pulse_cnt == pc0, "R5 idle oscillator counts nothing", pulse_cnt - pc0, 0);
    cfg_enable = 1'b0;

    // R7 R6: halt with oscillator source keeps counting, divider frozen
    osc_tick = 1'b1; halt = 1'b1;
    arm(3'd0, p);
    s0 = sync_out;
    exp_q.push_back(p + 1 + 256);
    wait_until(p + 100);
    chk(sync_out == s0, "R6 sync_out frozen in halt", sync_out, s0);
    chk(icyc_en == 1'b0, "R6 icyc_en low in halt", icyc_en, 0);
    wait_until(p + 262);
    stop("R7 pulse during halt");
    halt = 1'b0;

    // R8: shrink ratio mid count below the prescaler value already reached
    arm(3'd7, p);
    wait_until(p + 800); sel_we = 1'b1; sel_wdata = 3'd1;
    wait_until(p + 801); sel_we = 1'b0;
    chk(sel_q == 3'd1, "R8 sel_q loaded", sel_q, 1);
    exp_q.push_back(p + 1 + 1024);
    wait_until(p + 1030);
    stop("R8 pulse after select change");

    // R2: largest ratio 1:128
    arm(3'd7, p);
    exp_q.push_back(p + 1 + 32768);
    wait_until(p + 32775);
    stop("R2 1:128 pulse seen");

    // R9: disabled, writes and clears ignored, no pulses
    @(negedge clk);
    cfg_enable = 1'b0; sel_we = 1'b1; sel_wdata = 3'd2; clr_wdt = 1'b1;
    @(negedge clk);
    sel_we = 1'b0; clr_wdt = 1'b0;
    @(negedge clk);
    chk(sel_q == 3'd7, "R9 select write ignored", sel_q, 7);
    pc0 = pulse_cnt;
    repeat (600) @(negedge clk);
    chk(pulse_cnt == pc0, "R9 no pulse while disabled", pulse_cnt - pc0, 0);

    // R5 R3: instruction-rate source, period 1024 cycles at ratio 1:1
    cfg_use_osc = 1'b0; osc_tick = 1'b1;
    want_catch = 1'b1; caught = -1;
    arm(3'd0, p);
    wait_until(p + 1030);
    chk(caught >= p + 1022 && caught <= p + 1025, "R5 instruction-rate first pulse", caught, p + 1022);
    want_catch = 1'b0;
    if (caught > 0) begin
      exp_q.push_back(caught + 1024);
      exp_q.push_back(caught + 2048);
      wait_until(caught + 2052);
    end
    stop("R3 instruction-rate restart");

    // R6 R5: halt stops the instruction-rate source
    halt = 1'b1;
    pc0 = pulse_cnt;
    arm(3'd0, p);
    wait_until(p + 1500);
    chk(pulse_cnt == pc0, "R6 halted instruction source", pulse_cnt - pc0, 0);
    cfg_enable = 1'b0; halt = 1'b0;

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", pcyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule